// File: doc/BRIEF.md
# Multi-function pad control cell

This cell sits between one external pad and eight internal peripheral signal sets. A 32-bit configuration word is written over a simple register bus and reads back on the same bus. The word picks which of the eight sources owns the pad. It picks where the pull resistors are controlled from and what drive-strength code the pad receives. It also sets whether the pad is frozen to fixed values while the chip sleeps. The selected source's output and output-enable reach the pad. The pad input is returned only to the selected source.

The pad input also feeds an edge watcher. After a two-flop synchroniser, enabled rising or falling edges set a sticky status flag. A wakeup request is raised only while that flag is set and the external per-pad wakeup enable is high. The watcher is a three-state machine. ST_WATCH looks for enabled edges. ST_HELD holds a recorded edge. ST_OFF records nothing while the edge-clear bit is set. Its transitions are: *hit* (ST_WATCH to ST_HELD on an enabled edge); *clear* (any state to ST_OFF on a register write with bit 6 set); *arm* (ST_OFF to ST_WATCH once the stored bit 6 is 0). Reset enters ST_WATCH.

Top module: `padmux_cell`

## Requirements
- R1: After reset the register reads 32'h0000_0800: source 0, drive code 3'b010 in bits 12:10, and all other fields 0. The edge flag and wakeup request are 0.
- R2: A write takes effect on the next clock edge. Bits 15:4 and 2:0 store the written value. Bit 3 and bits 31:16 always read 0.
- R3: Bits 2:0 select source n. pad_out and pad_oe follow fn_out[n] and fn_oe[n]. fn_in[n] carries pad_in and every other fn_in bit is 0.
- R4: With bit 15 at 0, pad_pu and pad_pd follow fn_pu[n] and fn_pd[n] of the selected source.
- R5: With bit 15 at 1, bit 14 drives pad_pu and bit 13 drives pad_pd. If both are set, pad_pd is 1 and pad_pu is forced to 0.
- R6: pad_drv always equals bits 12:10.
- R7: While sleep_i is 1 and bit 9 is 1, pad_out equals bit 8 and pad_oe equals the inverse of bit 7, without waiting for a clock. If either of these is 0, the selected source drives the pad.
- R8: With bit 4 set, a rising edge on pad_in sets edge_seen within four clock cycles. A falling edge alone does not set it.
- R9: With bit 5 set, a falling edge on pad_in sets edge_seen. A rising edge alone does not set it.
- R10: A write with bit 6 set clears edge_seen on the next clock. While bit 6 is stored, no edge is recorded.
- R11: wake_req is 1 exactly when edge_seen and wake_en are both 1.
- R12: edge_seen stays 1 through further pad activity and through writes that leave bit 6 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| fn_out | input | 8 | Output of each source |
| fn_oe | input | 8 | Output enable of each source |
| fn_pu | input | 8 | Pull-up request of each source |
| fn_pd | input | 8 | Pull-down request of each source |
| fn_in | output | 8 | Pad input returned to the selected source |
| sleep_i | input | 1 | Low-power mode active |
| wake_en | input | 1 | Per-pad wakeup enable |
| pad_in | input | 1 | Pad receiver value (asynchronous) |
| pad_out | output | 1 | Pad output data |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| pad_drv | output | 3 | Drive-strength and slew code |
| edge_seen | output | 1 | Sticky edge status |
| wake_req | output | 1 | Wakeup request |

## Verification
On every cycle, the assertions check these properties:
- Register writes store their masked value.
- At most one source sees the pad input.
- The register-controlled pulls are never both on.
- A clearing write empties the edge flag.
- The flag stays cleared while the clear bit is stored.
- The flag only drops through a clearing write.

Whether an edge of the enabled polarity is recorded and the other polarity ignored depends on pad stimulus through the synchroniser. So do the sleep override values and the gating of wakeup by wake_en. These are shown only by the bench's directed edge scenarios and randomly drawn configurations.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
    localparam int CFG_W     = 32;
    localparam int B_RISE    = 4;
    localparam int B_FALL    = 5;
    localparam int B_ECLR    = 6;
    localparam int B_SLP_OEN = 7;
    localparam int B_SLP_DAT = 8;
    localparam int B_SLP_SEL = 9;
    localparam int DRV_LO    = 10;
    localparam int DRV_W     = 3;
    localparam int B_PD      = 13;
    localparam int B_PU      = 14;
    localparam int B_PSRC    = 15;
    localparam logic [CFG_W-1:0] CFG_WMASK = 32'h0000_FFF7;
    localparam logic [CFG_W-1:0] CFG_RST   = 32'h0000_0800;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_HELD  = 2'd2
    } edge_st_t;
endpackage

// File: rtl/padmux_cfg_reg.sv
module padmux_cfg_reg #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    WMASK = '1,
    parameter logic [W-1:0]    RSTV  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_q <= RSTV;
        else if (wr_en) cfg_q <= wr_data & WMASK;
    end

    // R2: written value lands masked on the following edge
    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == ($past(wr_data) & WMASK)));
endmodule

// File: rtl/padmux_route.sv
module padmux_route #(
    parameter int NUM_FUNC = 8,
    parameter int DRV_W    = 3,
    localparam int SEL_W   = $clog2(NUM_FUNC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic                slp_sel,
    input  logic                slp_oen,
    input  logic                slp_dat,
    input  logic                psrc,
    input  logic                pu_bit,
    input  logic                pd_bit,
    input  logic [DRV_W-1:0]    drv,
    input  logic                sleep_i,
    input  logic [NUM_FUNC-1:0] fn_out,
    input  logic [NUM_FUNC-1:0] fn_oe,
    input  logic [NUM_FUNC-1:0] fn_pu,
    input  logic [NUM_FUNC-1:0] fn_pd,
    input  logic                pad_in,
    output logic [NUM_FUNC-1:0] fn_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                pad_pu,
    output logic                pad_pd,
    output logic [DRV_W-1:0]    pad_drv
);
    logic frozen;

    always_comb begin
        frozen = sleep_i & slp_sel;
        if (frozen) begin
            pad_out = slp_dat;
            pad_oe  = ~slp_oen;
        end else begin
            pad_out = fn_out[sel];
            pad_oe  = fn_oe[sel];
        end
        if (psrc) begin
            pad_pd = pd_bit;
            pad_pu = pu_bit & ~pd_bit;
        end else begin
            pad_pd = fn_pd[sel];
            pad_pu = fn_pu[sel];
        end
        pad_drv = drv;
    end

    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_ret
        assign fn_in[i] = (sel == SEL_W'(i)) ? pad_in : 1'b0;
    end

    // R3: the pad input reaches at most one source
    assert_single_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fn_in));
    // R5: register-controlled pulls never fight
    assert_pull_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        psrc |-> !(pad_pu && pad_pd));
endmodule

// File: rtl/padmux_edge_fsm.sv
module padmux_edge_fsm
    import padmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr_stored,
    input  logic clr_write,
    input  logic wake_en,
    output logic edge_seen,
    output logic wake_req
);
    logic [SYNC_STAGES:0] shr;
    logic                 now_lvl, old_lvl, hit;
    edge_st_t             st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shr <= '0;
        else        shr <= {shr[SYNC_STAGES-1:0], pad_in};
    end

    assign now_lvl = shr[SYNC_STAGES-1];
    assign old_lvl = shr[SYNC_STAGES];
    assign hit     = (rise_en & now_lvl & ~old_lvl) | (fall_en & ~now_lvl & old_lvl);

    always_comb begin
        st_d = st_q;
        if (clr_write) st_d = ST_OFF;
        else begin
            unique case (st_q)
                ST_OFF:   if (!clr_stored) st_d = ST_WATCH;
                ST_WATCH: if (hit)         st_d = ST_HELD;
                ST_HELD:  st_d = ST_HELD;
                default:  st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WATCH;
        else        st_q <= st_d;
    end

    always_comb begin
        edge_seen = (st_q == ST_HELD);
        wake_req  = edge_seen & wake_en;
    end

    // R10: clearing write empties the flag
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_write |=> !edge_seen);
    // R10: nothing is recorded while the clear bit is stored
    assert_no_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stored && !edge_seen) |=> !edge_seen);
    // R12: flag drops only through a clearing write
    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !clr_write) |=> edge_seen);
endmodule

// File: rtl/padmux_cell.sv
module padmux_cell
    import padmux_pkg::*;
#(
    parameter int NUM_FUNC    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_FUNC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wr_data,
    output logic [CFG_W-1:0]    rd_data,
    input  logic [NUM_FUNC-1:0] fn_out,
    input  logic [NUM_FUNC-1:0] fn_oe,
    input  logic [NUM_FUNC-1:0] fn_pu,
    input  logic [NUM_FUNC-1:0] fn_pd,
    output logic [NUM_FUNC-1:0] fn_in,
    input  logic                sleep_i,
    input  logic                wake_en,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                pad_pu,
    output logic                pad_pd,
    output logic [DRV_W-1:0]    pad_drv,
    output logic                edge_seen,
    output logic                wake_req
);
    logic [CFG_W-1:0] cfg_q;

    padmux_cfg_reg #(.W(CFG_W), .WMASK(CFG_WMASK), .RSTV(CFG_RST)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q)
    );

    assign rd_data = cfg_q;

    padmux_route #(.NUM_FUNC(NUM_FUNC), .DRV_W(DRV_W)) u_route (
        .clk(clk), .rst_n(rst_n),
        .sel(cfg_q[SEL_W-1:0]),
        .slp_sel(cfg_q[B_SLP_SEL]), .slp_oen(cfg_q[B_SLP_OEN]), .slp_dat(cfg_q[B_SLP_DAT]),
        .psrc(cfg_q[B_PSRC]), .pu_bit(cfg_q[B_PU]), .pd_bit(cfg_q[B_PD]),
        .drv(cfg_q[DRV_LO +: DRV_W]),
        .sleep_i(sleep_i),
        .fn_out(fn_out), .fn_oe(fn_oe), .fn_pu(fn_pu), .fn_pd(fn_pd),
        .pad_in(pad_in), .fn_in(fn_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_drv(pad_drv)
    );

    padmux_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .rise_en(cfg_q[B_RISE]), .fall_en(cfg_q[B_FALL]),
        .clr_stored(cfg_q[B_ECLR]), .clr_write(wr_en & wr_data[B_ECLR]),
        .wake_en(wake_en), .edge_seen(edge_seen), .wake_req(wake_req)
    );
endmodule

// File: tb/padmux_cell_bench.sv
module padmux_cell_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  fn_out = '0, fn_oe = '0, fn_pu = '0, fn_pd = '0, fn_in;
    logic        sleep_i = 1'b0, wake_en = 1'b0, pad_in = 1'b0;
    logic        pad_out, pad_oe, pad_pu, pad_pd, edge_seen, wake_req;
    logic [2:0]  pad_drv;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    padmux_cell u_padmux_cell (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fn_out(fn_out), .fn_oe(fn_oe), .fn_pu(fn_pu), .fn_pd(fn_pd), .fn_in(fn_in),
        .sleep_i(sleep_i), .wake_en(wake_en), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_drv(pad_drv), .edge_seen(edge_seen), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected pad controls {out, oe, pu, pd} from the requirement text
    function automatic logic [3:0] exp_pad(input logic [31:0] c, input logic slp);
        logic [2:0] s;
        logic o, e, u, d;
        s = c[2:0];
        if (slp && c[9]) begin o = c[8]; e = ~c[7]; end
        else begin o = fn_out[s]; e = fn_oe[s]; end
        if (c[15]) begin d = c[13]; u = c[14] & ~c[13]; end
        else begin u = fn_pu[s]; d = fn_pd[s]; end
        return {o, e, u, d};
    endfunction

    function automatic logic [7:0] exp_ret(input logic [31:0] c, input logic p);
        logic [7:0] r;
        r = '0;
        r[c[2:0]] = p;
        return r;
    endfunction

    task automatic wr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; #1;
    endtask

    task automatic pad_to(input logic v);
        @(negedge clk); pad_in = v;
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] w, exp_c;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 reset value", rd_data, 32'h0000_0800);
        chk("R1 reset drive", {29'd0, pad_drv}, 32'd2);
        chk("R1 reset flag", {31'd0, edge_seen}, 32'd0);
        chk("R1 reset wake", {31'd0, wake_req}, 32'd0);

        // R2 reserved bits
        wr(32'hFFFF_FFFF);
        chk("R2 reserved read zero", rd_data, 32'h0000_FFF7);
        // R5 both pulls set
        wr(32'h0000_E000);
        chk("R5 pulldown wins", {30'd0, pad_pu, pad_pd}, 32'd1);

        // R7 sleep override directed
        fn_out = 8'h00; fn_oe = 8'h00;
        wr(32'h0000_0300);
        sleep_i = 1'b1; #1;
        chk("R7 sleep out/oe", {30'd0, pad_out, pad_oe}, 32'd3);
        sleep_i = 1'b0; #1;
        chk("R7 awake uses source", {30'd0, pad_out, pad_oe}, 32'd0);

        // R8 rising edge, R11 wakeup gating
        wr(32'h0000_0010);
        repeat (3) @(negedge clk);
        pad_to(1'b1);
        chk("R8 rise recorded", {31'd0, edge_seen}, 32'd1);
        chk("R11 no wake without enable", {31'd0, wake_req}, 32'd0);
        wake_en = 1'b1; #1;
        chk("R11 wake with enable", {31'd0, wake_req}, 32'd1);
        // R12 sticky
        pad_to(1'b0);
        wr(32'h0000_0020);
        pad_to(1'b1);
        chk("R12 flag stays set", {31'd0, edge_seen}, 32'd1);
        // R10 clear and blocking
        wr(32'h0000_0070);
        chk("R10 clear write", {31'd0, edge_seen}, 32'd0);
        chk("R11 wake drops", {31'd0, wake_req}, 32'd0);
        pad_to(1'b0);
        pad_to(1'b1);
        chk("R10 no record while clear stored", {31'd0, edge_seen}, 32'd0);

        // R9 falling only (pad now 1)
        wr(32'h0000_0020);
        repeat (3) @(negedge clk);
        chk("R9 nothing yet", {31'd0, edge_seen}, 32'd0);
        pad_to(1'b0);
        chk("R9 fall recorded", {31'd0, edge_seen}, 32'd1);
        wr(32'h0000_0040);
        pad_to(1'b1);
        wr(32'h0000_0020);
        repeat (3) @(negedge clk);
        pad_to(1'b0);
        pad_to(1'b1);
        chk("R9 rise ignored when fall only... fall seen", {31'd0, edge_seen}, 32'd1);
        // R8 fall ignored with rise only (pad now 1)
        wr(32'h0000_0040);
        wr(32'h0000_0010);
        repeat (3) @(negedge clk);
        pad_to(1'b0);
        chk("R8 fall ignored", {31'd0, edge_seen}, 32'd0);
        wr(32'h0000_0040);
        wr(32'h0000_0020);
        repeat (3) @(negedge clk);
        pad_to(1'b1);
        chk("R9 rise ignored", {31'd0, edge_seen}, 32'd0);
        wake_en = 1'b0;

        // Random configurations: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 300; k++) begin
            logic [3:0] ep;
            w = $urandom();
            if (k % 4 == 0) w[15] = 1'b1;
            exp_c = w & 32'h0000_FFF7;
            wr(w);
            fn_out = 8'($urandom()); fn_oe = 8'($urandom());
            fn_pu = 8'($urandom()); fn_pd = 8'($urandom());
            sleep_i = 1'($urandom()); pad_in = 1'($urandom());
            #1;
            ep = exp_pad(exp_c, sleep_i);
            chk("R2 readback", rd_data, exp_c);
            chk("R3 R7 pad out/oe", {30'd0, pad_out, pad_oe}, {30'd0, ep[3:2]});
            chk(exp_c[15] ? "R5 reg pulls" : "R4 source pulls",
                {30'd0, pad_pu, pad_pd}, {30'd0, ep[1:0]});
            chk("R6 drive code", {29'd0, pad_drv}, {29'd0, exp_c[12:10]});
            chk("R3 input return", {24'd0, fn_in}, {24'd0, exp_ret(exp_c, pad_in)});
        end
        finish_run();
    end
endmodule